// File: doc/BRIEF.md
# Coarse Delay Pulse Generator

This block sits in one channel of a programmable edge-placement path and runs on the high-speed clock. Each event strobe arrives with a timeset code. The upper part of the code is a coarse delay counted in whole high-speed cycles. The lower part is a fine code for an analog vernier that follows this block and is not part of it. The event travels through a tapped shift register for the coarse number of cycles. It then produces a fixed-width active-low output pulse, and the fine code is presented in step with that pulse.

Events must be spaced by a minimum number of cycles. An event that arrives too early is discarded, and a sticky flag records the violation. In half-span mode the coarse range is cut to its lower half, so that events can be issued twice as often without a pending token being overtaken.

Two events can still be in flight together. If both land on the same cycle, the newer one replaces the older. If one reaches the output while the other's pulse is still low, the pulse is extended.

Top module: `cdly_pulse_gen`

## Requirements
- R1: After reset, pulse_n_o is 1, fine_o is 0, refire_viol_o is 0, and no token from before the reset ever produces a pulse.
- R2: The coarse delay c is tset_i[9:7], taken as an unsigned number from 0 to 7. For an event accepted at clock edge k, pulse_n_o first reads 0 after edge k+c+1.
- R3: An isolated pulse keeps pulse_n_o at 0 for exactly 2 cycles, after edges k+c+1 and k+c+2, and returns to 1 after edge k+c+3.
- R4: fine_o takes tset_i[6:0] of the event at the edge where that event's pulse begins. It holds that value until the next pulse begins, and it never changes while pulse_n_o is 1.
- R5: An event sampled fewer than 4 edges after the last accepted event is dropped and produces no pulse. An event exactly 4 or more edges later is accepted.
- R6: A dropped event sets refire_viol_o after that same edge. The flag stays at 1 until reset.
- R7: A dropped event does not restart the spacing window. The window is always measured from the last accepted event.
- R8: When half_span_i is 1, tset_i[9] is ignored, so the coarse delay is tset_i[8:7] (0 to 3).
- R9: When two accepted events have the same pulse start edge, a single 2-cycle pulse is produced, and it carries the fine code of the newer event.
- R10: When an event's start edge falls while an earlier pulse is still low, the low time is extended to 2 cycles from the new start. fine_o switches to the new code at the new start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| evt_i | input | 1 | Event strobe, sampled on each rising edge |
| tset_i | input | 10 | Timeset code: [9:7] coarse delay, [6:0] fine code |
| half_span_i | input | 1 | 1 selects half-span mode, in which tset_i[9] is ignored |
| pulse_n_o | output | 1 | Active-low output pulse |
| fine_o | output | 7 | Fine code for the vernier, aligned with the pulse |
| refire_viol_o | output | 1 | Sticky flag for a dropped, too-early event |

## Verification
Two pieces of logic can act in the same cycle, and the bench drives each case on purpose.

In the first case, a new event is loaded into the shift register at the very tap that an older token is shifting into. An event with coarse 7 is followed 4 cycles later by one with coarse 3, so both aim at the same start edge. The check is that only one 2-cycle pulse appears and that it carries the second fine code.

In the second case, a token reaches the output stage while the pulse shaper is still counting out an earlier pulse. An event with coarse 5 is followed by one with coarse 2, so the starts fall one cycle apart. The check is a 3-cycle low run, with fine_o changing on the second low cycle.

Every cycle of both runs is compared against a waveform that the bench builds from the start-edge arithmetic.

// File: rtl/cdly_pkg.sv
package cdly_pkg;
  localparam int COARSE_W_DEF = 3;
  localparam int FINE_W_DEF   = 7;
  localparam int MIN_GAP_DEF  = 4;
  localparam int PULSE_W_DEF  = 2;
endpackage

// File: rtl/cdly_refire_guard.sv
module cdly_refire_guard #(
  parameter int MIN_GAP = cdly_pkg::MIN_GAP_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  output logic accept_o,
  output logic viol_o
);
  localparam int CNT_W = $clog2(MIN_GAP + 1);
  localparam logic [CNT_W-1:0] GAP_LIM = CNT_W'(MIN_GAP);

  logic [CNT_W-1:0] gap_q, gap_d;
  logic             viol_q, viol_d;
  logic             ready, reject, gap_en;

  assign ready    = (gap_q >= GAP_LIM);
  assign accept_o = evt_i & ready;
  assign reject   = evt_i & ~ready;
  assign gap_en   = accept_o | ~ready;
  assign viol_o   = viol_q;

  always_comb begin
    gap_d  = gap_q;
    viol_d = viol_q | reject;
    if (accept_o) begin
      gap_d = CNT_W'(1);
    end else if (!ready) begin
      gap_d = gap_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= GAP_LIM;
      viol_q <= 1'b0;
    end else begin
      if (gap_en) gap_q <= gap_d;
      viol_q <= viol_d;
    end
  end

  // R6
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |=> viol_o);

  // R5
  refire_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !accept_o);
endmodule

// File: rtl/cdly_shifter.sv
module cdly_shifter #(
  parameter int COARSE_W = cdly_pkg::COARSE_W_DEF,
  parameter int FINE_W   = cdly_pkg::FINE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [COARSE_W-1:0] slot_i,
  input  logic [FINE_W-1:0]   fine_i,
  output logic                head_vld_o,
  output logic [FINE_W-1:0]   head_fine_o
);
  localparam int DEPTH = 1 << COARSE_W;

  logic [DEPTH-1:0]  vld_q, vld_d, fine_en;
  logic [FINE_W-1:0] fine_q [DEPTH];
  logic [FINE_W-1:0] fine_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              up_vld, hit;
    logic [FINE_W-1:0] up_fine;
    if (i == DEPTH - 1) begin : g_top
      assign up_vld  = 1'b0;
      assign up_fine = '0;
    end else begin : g_mid
      assign up_vld  = vld_q[i+1];
      assign up_fine = fine_q[i+1];
    end
    // a new load takes the tap even if an older token is shifting into it
    assign hit        = load_i && (slot_i == COARSE_W'(i));
    assign vld_d[i]   = hit | up_vld;
    assign fine_en[i] = hit | up_vld;
    assign fine_d[i]  = hit ? fine_i : up_fine;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) fine_q[i] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < DEPTH; i++) begin
        if (fine_en[i]) fine_q[i] <= fine_d[i];
      end
    end
  end

  assign head_vld_o  = vld_q[0];
  assign head_fine_o = fine_q[0];

  // R2
  slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && slot_i == '0) |=> head_vld_o);
endmodule

// File: rtl/cdly_pulse_shaper.sv
module cdly_pulse_shaper #(
  parameter int FINE_W  = cdly_pkg::FINE_W_DEF,
  parameter int PULSE_W = cdly_pkg::PULSE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_i,
  input  logic [FINE_W-1:0] tok_fine_i,
  output logic              pulse_n_o,
  output logic [FINE_W-1:0] fine_o
);
  localparam int REM_W = $clog2(PULSE_W + 1);
  localparam logic [REM_W-1:0] REM_LOAD = REM_W'(PULSE_W - 1);

  logic              low_q, low_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [FINE_W-1:0] fine_q;

  always_comb begin
    low_d = 1'b0;
    rem_d = rem_q;
    if (tok_i) begin
      low_d = 1'b1;
      rem_d = REM_LOAD;
    end else if (rem_q != '0) begin
      low_d = 1'b1;
      rem_d = rem_q - REM_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= 1'b0;
      rem_q  <= '0;
      fine_q <= '0;
    end else begin
      low_q <= low_d;
      rem_q <= rem_d;
      if (tok_i) fine_q <= tok_fine_i;
    end
  end

  assign pulse_n_o = ~low_q;
  assign fine_o    = fine_q;

  // R4
  fine_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fine_o) |-> !pulse_n_o);

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_n_o) |=> !pulse_n_o);
endmodule

// File: rtl/cdly_pulse_gen.sv
module cdly_pulse_gen #(
  parameter int COARSE_W = cdly_pkg::COARSE_W_DEF,
  parameter int FINE_W   = cdly_pkg::FINE_W_DEF,
  parameter int MIN_GAP  = cdly_pkg::MIN_GAP_DEF,
  parameter int PULSE_W  = cdly_pkg::PULSE_W_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         evt_i,
  input  logic [COARSE_W+FINE_W-1:0]   tset_i,
  input  logic                         half_span_i,
  output logic                         pulse_n_o,
  output logic [FINE_W-1:0]            fine_o,
  output logic                         refire_viol_o
);
  localparam int TS_W = COARSE_W + FINE_W;

  logic                accept;
  logic [COARSE_W-1:0] coarse_raw, coarse_mask, coarse_eff;
  logic                head_vld;
  logic [FINE_W-1:0]   head_fine;

  assign coarse_raw  = tset_i[TS_W-1 -: COARSE_W];
  assign coarse_mask = half_span_i ? {1'b0, {(COARSE_W-1){1'b1}}} : '1;
  assign coarse_eff  = coarse_raw & coarse_mask;

  cdly_refire_guard #(.MIN_GAP(MIN_GAP)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .accept_o (accept),
    .viol_o   (refire_viol_o)
  );

  cdly_shifter #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept),
    .slot_i      (coarse_eff),
    .fine_i      (tset_i[FINE_W-1:0]),
    .head_vld_o  (head_vld),
    .head_fine_o (head_fine)
  );

  cdly_pulse_shaper #(.FINE_W(FINE_W), .PULSE_W(PULSE_W)) u_shape (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_i      (head_vld),
    .tok_fine_i (head_fine),
    .pulse_n_o  (pulse_n_o),
    .fine_o     (fine_o)
  );

  // R2
  head_to_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_vld |=> !pulse_n_o);

  // R10
  retrig_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_vld |=> (fine_o == $past(head_fine)));
endmodule

// File: tb/cdly_pulse_gen_tb.sv
module cdly_pulse_gen_tb;
  localparam int LEN = 100;
  localparam int EXT = LEN + 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       evt_i;
  logic [9:0] tset_i;
  logic       half_span_i;
  logic       pulse_n_o;
  logic [6:0] fine_o;
  logic       refire_viol_o;

  always #5 clk = ~clk;

  cdly_pulse_gen u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_i         (evt_i),
    .tset_i        (tset_i),
    .half_span_i   (half_span_i),
    .pulse_n_o     (pulse_n_o),
    .fine_o        (fine_o),
    .refire_viol_o (refire_viol_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic       ev_a [LEN];
  logic [9:0] ts_a [LEN];
  logic       st_v [EXT];
  logic [6:0] st_f [EXT];
  logic       exp_low  [LEN];
  logic [6:0] exp_fine [LEN];
  logic       exp_viol [LEN];

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int n = 0; n < LEN; n++) begin
      ev_a[n] = 1'b0;
      ts_a[n] = 10'h3ff;
    end
  endtask

  task automatic add_ev(input int n, input int c, input int f);
    ev_a[n] = 1'b1;
    ts_a[n] = {3'(c), 7'(f)};
  endtask

  // expected waveform from start-edge arithmetic
  task automatic build_model(input logic half);
    int   last;
    logic v;
    logic [6:0] cur;
    last = -100;
    v    = 1'b0;
    for (int t = 0; t < EXT; t++) begin
      st_v[t] = 1'b0;
      st_f[t] = '0;
    end
    for (int n = 0; n < LEN; n++) begin
      if (ev_a[n]) begin
        if (n - last >= 4) begin
          int c;
          last = n;
          c = half ? int'(ts_a[n][8:7]) : int'(ts_a[n][9:7]);
          st_v[n+c+1] = 1'b1;       // newer event overwrites (R9)
          st_f[n+c+1] = ts_a[n][6:0];
        end else begin
          v = 1'b1;
        end
      end
      exp_viol[n] = v;
    end
    cur = '0;
    for (int t = 0; t < LEN; t++) begin
      if (st_v[t]) cur = st_f[t];
      exp_low[t]  = st_v[t] || (t > 0 && st_v[t-1]);
      exp_fine[t] = cur;
    end
  endtask

  task automatic run(input string tag, input logic half);
    build_model(half);
    @(negedge clk);
    rst_n       = 1'b0;
    evt_i       = 1'b0;
    tset_i      = '0;
    half_span_i = half;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    check("R1", "pulse_n", int'(pulse_n_o), 1);
    check("R1", "fine", int'(fine_o), 0);
    check("R1", "viol", int'(refire_viol_o), 0);
    for (int n = 0; n < LEN; n++) begin
      evt_i  = ev_a[n];
      tset_i = ts_a[n];
      @(posedge clk);
      #2;
      check(tag, "pulse_n", int'(pulse_n_o), int'(!exp_low[n]));
      check(tag, "fine", int'(fine_o), int'(exp_fine[n]));
      check(tag, "viol", int'(refire_viol_o), int'(exp_viol[n]));
      @(negedge clk);
    end
    evt_i = 1'b0;
  endtask

  initial begin
    rst_n       = 1'b0;
    evt_i       = 1'b0;
    tset_i      = '0;
    half_span_i = 1'b0;

    // R2 R3 R4: every coarse value, isolated events
    clear_stim();
    for (int c = 0; c < 8; c++) add_ev(2 + 12 * c, c, (c * 17 + 5) & 8'h7f);
    run("R2", 1'b0);

    // R8: same sweep in half-span mode, top coarse bit ignored
    run("R8", 1'b1);

    // R5 R6: spacing sweep, gaps 1..6
    for (int g = 1; g <= 6; g++) begin
      clear_stim();
      add_ev(2, 0, 7'h11);
      add_ev(2 + g, 0, 7'h22 + g);
      run((g < 4) ? "R5" : "R6", 1'b0);
    end

    // R7: rejected event does not restart the window
    clear_stim();
    add_ev(2, 1, 7'h0a);
    add_ev(5, 1, 7'h0b);
    add_ev(6, 1, 7'h0c);
    run("R7", 1'b0);

    // R9: same start edge, newer wins
    clear_stim();
    add_ev(2, 7, 7'h35);
    add_ev(6, 3, 7'h4a);
    run("R9", 1'b0);

    // R10: start lands during an active pulse
    clear_stim();
    add_ev(2, 5, 7'h61);
    add_ev(6, 2, 7'h1e);
    run("R10", 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule